// File: doc/BRIEF.md
# Dual-Port Word Memory with Same-Address Busy Arbitration

This block is a two-port word memory: a left port and a right port, each with its own address, write data, read data, read/write select, output enable, a pair of chip selects, per-lane write/read enables and a sleep input. Both ports reach every word of the array in the same clock cycle, including the same word. The array is a synchronous register array. Read data appears on the cycle after the address is presented.

An arbitration unit watches for both ports selecting the same word. A role strap sets how it acts. In master role, the block resolves the conflict itself, raises a busy flag to the losing port and blocks that port's write for the cycle. In slave role, the block drives no busy flag. Instead, a busy input from an external master blocks the matching port's writes. Wider data paths are built by strapping one instance as master and feeding its busy outputs into the busy inputs of the other instances.

Each 36-bit word is split into four 9-bit lanes. Each lane can be written and read on its own. A parameter halves the usable depth; in that case the most significant address bit is ignored.

Top module: `dparb_ram`

## Requirements
- R1: The two ports access different words in the same cycle without affecting each other, and neither port's busy flag rises.
- R2: Lane k covers data bits 9k to 9k+8. `*_lane_n[k]` is active low. A write changes only the enabled lanes. On a read, disabled lanes return 0.
- R3: A port is selected only when `*_cs0_n` is 0 and `*_cs1` is 1. A port that is not selected writes nothing, and its read data is 0.
- R4: Read data shows the addressed word on the cycle after a selected port presents `*_wr_n`=1 and `*_oe_n`=0. After any other cycle of an awake port, read data is 0. `*_wr_n`=0 means write.
- R5: When one port writes a word and the other port reads that word in the same cycle, the read returns the value from before the write.
- R6: In master role (`ms_master`=1), when both active ports select the same word and neither was already on it, the left port wins. `rt_busy` rises, the right port's write is blocked, and at most one busy flag is high.
- R7: In master role, a port that was already on a word before the other port arrives keeps priority. The late port sees busy, and its write is blocked until the first port leaves that word.
- R8: In slave role (`ms_master`=0), both busy outputs stay 0. A high `*_busy_in` blocks that port's writes but not its reads. If both ports write the same lanes of one word, the left data is stored.
- R9: While `*_sleep` is 1, the port ignores its other inputs. It writes nothing, its read data holds its last value, and it takes no part in arbitration.
- R10: With `HALF_DEPTH`=1, the top address bit is ignored for storage and for collision detection, so two addresses that differ only in that bit reach the same word.
- R11: During and right after reset, both read data outputs and both busy flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_master | input | 1 | Role strap: 1 master, 0 slave |
| lt_addr | input | ADDR_W | Left word address |
| lt_wdata | input | 36 | Left write data |
| lt_rdata | output | 36 | Left read data |
| lt_wr_n | input | 1 | Left read/write select, 0 = write |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_cs0_n | input | 1 | Left chip select, active low |
| lt_cs1 | input | 1 | Left chip select, active high |
| lt_lane_n | input | 4 | Left lane enables, active low |
| lt_sleep | input | 1 | Left sleep |
| lt_busy_in | input | 1 | Left busy from external master (slave role) |
| lt_busy | output | 1 | Left busy flag (master role) |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | 36 | Right write data |
| rt_rdata | output | 36 | Right read data |
| rt_wr_n | input | 1 | Right read/write select, 0 = write |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_cs0_n | input | 1 | Right chip select, active low |
| rt_cs1 | input | 1 | Right chip select, active high |
| rt_lane_n | input | 4 | Right lane enables, active low |
| rt_sleep | input | 1 | Right sleep |
| rt_busy_in | input | 1 | Right busy from external master (slave role) |
| rt_busy | output | 1 | Right busy flag (master role) |

## Verification
The bench uses a 16-word configuration with the top address bit ignored. It fills and reads back every word through both ports at once on disjoint addresses, which shows that the ports are independent and that no false busy appears. It sweeps all 16 lane masks over one word, which separates a stored lane from a masked one and a driven lane from a zeroed one. Same-word traffic is tried in four forms: fresh arrival in both roles, one port arriving before the other, write against read, and aliased addresses. These show which port wins, when the write is blocked and which data is read. Sleep and chip-select patterns show that a port in these states leaves the array, its output and the arbiter unchanged.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

   typedef enum logic {
      PRIO_LEFT  = 1'b0,
      PRIO_RIGHT = 1'b1
   } prio_e;

endpackage

// File: rtl/dparb_port_decode.sv
module dparb_port_decode #(
   parameter int ADDR_W     = 6,
   parameter int HALF_DEPTH = 0,
   parameter int LANES      = 4,
   localparam int IW        = ADDR_W - HALF_DEPTH
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic              cs0_n,
   input  logic              cs1,
   input  logic [LANES-1:0]  lane_n,
   input  logic              sleep,
   output logic [IW-1:0]     idx,
   output logic              active,
   output logic              wr_req,
   output logic              rd_req,
   output logic [LANES-1:0]  lane_en
);

   generate
      if (HALF_DEPTH != 0) begin : g_half
         assign idx = addr[IW-1:0];
      end else begin : g_full
         assign idx = addr;
      end
   endgenerate

   assign active  = !cs0_n && cs1 && !sleep;
   assign wr_req  = active && !wr_n;
   assign rd_req  = active && wr_n && !oe_n;
   assign lane_en = ~lane_n;

endmodule

// File: rtl/dparb_arbiter.sv
module dparb_arbiter
   import dparb_pkg::*;
#(
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master,
   input  logic          l_act,
   input  logic [IW-1:0] l_idx,
   input  logic          l_busy_in,
   input  logic          r_act,
   input  logic [IW-1:0] r_idx,
   input  logic          r_busy_in,
   output logic          l_busy_o,
   output logic          r_busy_o,
   output logic          l_block,
   output logic          r_block
);

   logic          pl_act, pr_act, armed;
   logic [IW-1:0] pl_idx, pr_idx;
   prio_e         pwin;
   logic          collide, l_was, r_was, r_wins;

   assign collide = l_act && r_act && (l_idx == r_idx);
   assign l_was   = pl_act && (pl_idx == l_idx);
   assign r_was   = pr_act && (pr_idx == r_idx);
   assign r_wins  = collide && r_was && (!l_was || pwin == PRIO_RIGHT);

   assign l_busy_o = master && r_wins;
   assign r_busy_o = master && collide && !r_wins;
   assign l_block  = master ? l_busy_o : l_busy_in;
   assign r_block  = master ? r_busy_o : r_busy_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pl_act <= 1'b0;
         pr_act <= 1'b0;
         pl_idx <= '0;
         pr_idx <= '0;
         pwin   <= PRIO_LEFT;
         armed  <= 1'b0;
      end else begin
         pl_act <= l_act;
         pr_act <= r_act;
         pl_idx <= l_idx;
         pr_idx <= r_idx;
         pwin   <= r_wins ? PRIO_RIGHT : PRIO_LEFT;
         armed  <= 1'b1;
      end
   end

   a_r6_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy_o && r_busy_o));

   a_r6_left_wins_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && master && collide && !($past(r_act) && $past(r_idx) == r_idx))
      |-> (r_busy_o && !l_busy_o));

   a_r7_early_right_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && master && collide && $past(r_act) && $past(r_idx) == r_idx
       && !($past(l_act) && $past(l_idx) == l_idx))
      |-> (l_busy_o && !r_busy_o));

   a_r8_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> (!l_busy_o && !r_busy_o));

endmodule

// File: rtl/dparb_array.sv
module dparb_array #(
   parameter int IW     = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    l_idx,
   input  logic [LANES-1:0] l_we,
   input  logic [DW-1:0]    l_wdata,
   input  logic             l_cap,
   output logic [DW-1:0]    l_q,
   input  logic [IW-1:0]    r_idx,
   input  logic [LANES-1:0] r_we,
   input  logic [DW-1:0]    r_wdata,
   input  logic             r_cap,
   output logic [DW-1:0]    r_q
);

   logic [DW-1:0] mem [DEPTH];

   // right lanes first so the left port's lanes take effect on a shared word
   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (r_we[k]) mem[r_idx][k*LANE_W +: LANE_W] <= r_wdata[k*LANE_W +: LANE_W];
      end
      for (int k = 0; k < LANES; k++) begin
         if (l_we[k]) mem[l_idx][k*LANE_W +: LANE_W] <= l_wdata[k*LANE_W +: LANE_W];
      end
   end

   // nonblocking capture sees the word as it was before this edge's writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_q <= '0;
         r_q <= '0;
      end else begin
         if (l_cap) l_q <= mem[l_idx];
         if (r_cap) r_q <= mem[r_idx];
      end
   end

endmodule

// File: rtl/dparb_ram.sv
module dparb_ram #(
   parameter int ADDR_W     = 6,
   parameter int HALF_DEPTH = 0,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   localparam int IW        = ADDR_W - HALF_DEPTH,
   localparam int DW        = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_master,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic [DW-1:0]     lt_wdata,
   output logic [DW-1:0]     lt_rdata,
   input  logic              lt_wr_n,
   input  logic              lt_oe_n,
   input  logic              lt_cs0_n,
   input  logic              lt_cs1,
   input  logic [LANES-1:0]  lt_lane_n,
   input  logic              lt_sleep,
   input  logic              lt_busy_in,
   output logic              lt_busy,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic [DW-1:0]     rt_wdata,
   output logic [DW-1:0]     rt_rdata,
   input  logic              rt_wr_n,
   input  logic              rt_oe_n,
   input  logic              rt_cs0_n,
   input  logic              rt_cs1,
   input  logic [LANES-1:0]  rt_lane_n,
   input  logic              rt_sleep,
   input  logic              rt_busy_in,
   output logic              rt_busy
);

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("dparb_ram: ADDR_W must lie in 2..12");
      end
      if (HALF_DEPTH != 0 && HALF_DEPTH != 1) begin : g_bad_half
         $error("dparb_ram: HALF_DEPTH must be 0 or 1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("dparb_ram: LANES and LANE_W must be positive");
      end
   endgenerate

   logic [IW-1:0]    l_idx, r_idx;
   logic             l_act, r_act, l_wr, r_wr, l_rd, r_rd;
   logic [LANES-1:0] l_len, r_len, l_we, r_we;
   logic             l_block, r_block;
   logic [DW-1:0]    l_q, r_q, l_bits, r_bits;
   logic [LANES-1:0] l_show, r_show;

   dparb_port_decode #(.ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH), .LANES(LANES)) u_ldec (
      .addr(lt_addr), .wr_n(lt_wr_n), .oe_n(lt_oe_n), .cs0_n(lt_cs0_n), .cs1(lt_cs1),
      .lane_n(lt_lane_n), .sleep(lt_sleep), .idx(l_idx), .active(l_act),
      .wr_req(l_wr), .rd_req(l_rd), .lane_en(l_len));

   dparb_port_decode #(.ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH), .LANES(LANES)) u_rdec (
      .addr(rt_addr), .wr_n(rt_wr_n), .oe_n(rt_oe_n), .cs0_n(rt_cs0_n), .cs1(rt_cs1),
      .lane_n(rt_lane_n), .sleep(rt_sleep), .idx(r_idx), .active(r_act),
      .wr_req(r_wr), .rd_req(r_rd), .lane_en(r_len));

   dparb_arbiter #(.IW(IW)) u_arb (
      .clk(clk), .rst_n(rst_n), .master(ms_master),
      .l_act(l_act), .l_idx(l_idx), .l_busy_in(lt_busy_in),
      .r_act(r_act), .r_idx(r_idx), .r_busy_in(rt_busy_in),
      .l_busy_o(lt_busy), .r_busy_o(rt_busy), .l_block(l_block), .r_block(r_block));

   assign l_we = (l_wr && !l_block) ? l_len : '0;
   assign r_we = (r_wr && !r_block) ? r_len : '0;

   dparb_array #(.IW(IW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .l_idx(l_idx), .l_we(l_we), .l_wdata(lt_wdata), .l_cap(l_rd), .l_q(l_q),
      .r_idx(r_idx), .r_we(r_we), .r_wdata(rt_wdata), .r_cap(r_rd), .r_q(r_q));

   // lanes presented on the output, held while a port sleeps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_show <= '0;
         r_show <= '0;
      end else begin
         if (!lt_sleep) l_show <= l_rd ? l_len : '0;
         if (!rt_sleep) r_show <= r_rd ? r_len : '0;
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign l_bits[k*LANE_W +: LANE_W] = {LANE_W{l_show[k]}};
         assign r_bits[k*LANE_W +: LANE_W] = {LANE_W{r_show[k]}};
      end
   endgenerate

   assign lt_rdata = l_q & l_bits;
   assign rt_rdata = r_q & r_bits;

   a_r4_left_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_sleep && !(!lt_cs0_n && lt_cs1 && lt_wr_n && !lt_oe_n)) |=> (lt_rdata == '0));

   a_r4_right_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rt_sleep && !(!rt_cs0_n && rt_cs1 && rt_wr_n && !rt_oe_n)) |=> (rt_rdata == '0));

   a_r9_left_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lt_sleep |=> $stable(lt_rdata));

   a_r9_right_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rt_sleep |=> $stable(rt_rdata));

   a_r9_sleeper_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_sleep || rt_sleep) |-> (!lt_busy && !rt_busy));

endmodule

// File: tb/dparb_ram_tb.sv
`timescale 1ns/1ps
module dparb_ram_tb_top;

   localparam int AW = 5;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ms_master;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
   logic          l_wr_n, r_wr_n, l_oe_n, r_oe_n, l_cs0_n, r_cs0_n, l_cs1, r_cs1;
   logic [3:0]    l_lane_n, r_lane_n;
   logic          l_sleep, r_sleep, l_bin, r_bin, l_busy, r_busy;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   dparb_ram #(.ADDR_W(AW), .HALF_DEPTH(1), .LANES(4), .LANE_W(9)) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
      .lt_addr(l_addr), .lt_wdata(l_wdata), .lt_rdata(l_rdata), .lt_wr_n(l_wr_n),
      .lt_oe_n(l_oe_n), .lt_cs0_n(l_cs0_n), .lt_cs1(l_cs1), .lt_lane_n(l_lane_n),
      .lt_sleep(l_sleep), .lt_busy_in(l_bin), .lt_busy(l_busy),
      .rt_addr(r_addr), .rt_wdata(r_wdata), .rt_rdata(r_rdata), .rt_wr_n(r_wr_n),
      .rt_oe_n(r_oe_n), .rt_cs0_n(r_cs0_n), .rt_cs1(r_cs1), .rt_lane_n(r_lane_n),
      .rt_sleep(r_sleep), .rt_busy_in(r_bin), .rt_busy(r_busy));

   function automatic logic [DW-1:0] pat(input int a);
      logic [63:0] v;
      v = 64'h0_9A53_C17E * 64'(a + 3) + 64'h5A5;
      return v[DW-1:0];
   endfunction

   function automatic logic [DW-1:0] lmask(input logic [3:0] m);
      logic [DW-1:0] v;
      for (int k = 0; k < 4; k++) v[k*9 +: 9] = {9{m[k]}};
      return v;
   endfunction

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic l_idle();
      l_cs0_n = 1'b1; l_cs1 = 1'b0; l_wr_n = 1'b1; l_oe_n = 1'b1;
      l_lane_n = 4'h0; l_sleep = 1'b0; l_bin = 1'b0;
   endtask

   task automatic r_idle();
      r_cs0_n = 1'b1; r_cs1 = 1'b0; r_wr_n = 1'b1; r_oe_n = 1'b1;
      r_lane_n = 4'h0; r_sleep = 1'b0; r_bin = 1'b0;
   endtask

   task automatic l_wr(input int a, input logic [DW-1:0] d, input logic [3:0] ln);
      l_addr = AW'(a); l_wdata = d; l_lane_n = ln;
      l_cs0_n = 1'b0; l_cs1 = 1'b1; l_wr_n = 1'b0; l_oe_n = 1'b1;
   endtask

   task automatic r_wr(input int a, input logic [DW-1:0] d, input logic [3:0] ln);
      r_addr = AW'(a); r_wdata = d; r_lane_n = ln;
      r_cs0_n = 1'b0; r_cs1 = 1'b1; r_wr_n = 1'b0; r_oe_n = 1'b1;
   endtask

   task automatic l_rd(input int a, input logic [3:0] ln);
      l_addr = AW'(a); l_lane_n = ln;
      l_cs0_n = 1'b0; l_cs1 = 1'b1; l_wr_n = 1'b1; l_oe_n = 1'b0;
   endtask

   task automatic r_rd(input int a, input logic [3:0] ln);
      r_addr = AW'(a); r_lane_n = ln;
      r_cs0_n = 1'b0; r_cs1 = 1'b1; r_wr_n = 1'b1; r_oe_n = 1'b0;
   endtask

   // read one word through the left port with the right port idle
   task automatic peek(input int a, input logic [DW-1:0] exp, input string tag);
      l_idle(); r_idle(); l_rd(a, 4'h0);
      tick();
      chk(l_rdata, exp, tag);
      l_idle();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #200us;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] nv;
      rst_n = 1'b0; ms_master = 1'b1;
      l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
      l_idle(); r_idle();
      repeat (3) @(posedge clk);
      #1;
      chk(l_rdata, '0, "R11 left rdata in reset");
      chk({35'b0, l_busy | r_busy}, '0, "R11 busy in reset");
      rst_n = 1'b1;
      tick();
      chk(r_rdata, '0, "R11 right rdata after reset");

      // R1: fill lower and upper halves through both ports at once
      for (int i = 0; i < 8; i++) begin
         l_wr(i, pat(i), 4'h0);
         r_wr(i + 8, pat(i + 8), 4'h0);
         #1;
         chk({35'b0, l_busy | r_busy}, '0, "R1 no busy on disjoint writes");
         tick();
      end
      for (int j = 0; j < 16; j++) begin
         l_rd(j, 4'h0);
         r_rd(15 - j, 4'h0);
         tick();
         chk(l_rdata, pat(j), "R1 left read sweep");
         chk(r_rdata, pat(15 - j), "R1 R4 right read sweep");
      end
      l_idle(); r_idle();

      // R2: every lane mask on word 3
      for (int m = 0; m < 16; m++) begin
         l_wr(3, pat(3), 4'h0); r_idle();
         tick();
         l_idle(); r_wr(3, ~pat(3), ~4'(m));
         tick();
         r_idle(); l_rd(3, 4'h0);
         tick();
         nv = (~pat(3) & lmask(4'(m))) | (pat(3) & ~lmask(4'(m)));
         chk(l_rdata, nv, "R2 partial lane write");
         l_rd(3, ~4'(m));
         tick();
         chk(l_rdata, nv & lmask(4'(m)), "R2 disabled lanes read zero");
      end
      l_wr(3, pat(3), 4'h0);
      tick();
      l_idle();

      // R3: non-select combinations neither write nor drive data
      for (int c = 0; c < 4; c++) begin
         if (c == 1) continue;
         l_wr(5, ~pat(5), 4'h0);
         l_cs0_n = c[1]; l_cs1 = c[0];
         tick();
         l_idle();
         peek(5, pat(5), "R3 deselected write ignored");
         l_rd(5, 4'h0);
         l_cs0_n = c[1]; l_cs1 = c[0];
         tick();
         chk(l_rdata, '0, "R3 deselected read is zero");
      end
      l_idle();

      // R4: output enable off, or write cycle, gives zero
      l_rd(5, 4'h0); l_oe_n = 1'b1;
      tick();
      chk(l_rdata, '0, "R4 output enable off");
      l_wr(5, pat(5), 4'h0);
      tick();
      chk(l_rdata, '0, "R4 write cycle reads zero");
      l_idle();

      // R5 and R6: left writes word 6 while right reads it
      l_wr(6, 36'h1_2345_6789, 4'h0); r_rd(6, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h1, "R6 right busy on fresh collision");
      tick();
      chk(r_rdata, pat(6), "R5 read returns old word");
      l_idle(); r_idle();
      peek(6, 36'h1_2345_6789, "R5 write landed");

      // R6: both write word 7
      l_wr(7, 36'hA_AAAA_0001, 4'h0); r_wr(7, 36'h5_5555_0002, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h1, "R6 left wins write collision");
      tick();
      peek(7, 36'hA_AAAA_0001, "R6 right write blocked");
      r_idle();

      // R7: right arrives at word 9 first, left later
      r_rd(9, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h0, "R7 lone access not busy");
      tick();
      l_wr(9, 36'h0_BEEF_0009, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h2, "R7 late left port busy");
      tick();
      chk(r_rdata, pat(9), "R7 early right read intact");
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h2, "R7 busy held while right stays");
      tick();
      r_rd(10, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h0, "R7 busy drops when right leaves");
      tick();
      r_idle(); l_idle();
      peek(9, 36'h0_BEEF_0009, "R7 left write after release");

      // R10: top address bit ignored
      l_wr(2 + 16, 36'h7_0707_0202, 4'h0);
      tick();
      l_idle(); r_rd(2, 4'h0);
      tick();
      chk(r_rdata, 36'h7_0707_0202, "R10 aliased address same word");
      l_rd(4, 4'h0); r_rd(20, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h1, "R10 aliased collision detected");
      tick();
      l_idle(); r_idle();

      // R8: slave role
      ms_master = 1'b0;
      l_wr(11, 36'h1_1111_1111, 4'h0); r_wr(11, 36'h2_2222_2222, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h0, "R8 slave drives no busy");
      tick();
      l_idle(); r_idle();
      peek(11, 36'h1_1111_1111, "R8 left data kept on shared write");
      r_wr(12, 36'h3_3333_3333, 4'h0); r_bin = 1'b1;
      tick();
      r_idle();
      peek(12, pat(12), "R8 busy input blocks write");
      l_wr(13, 36'h4_4444_4444, 4'h0);
      tick();
      l_idle(); r_rd(13, 4'h0); r_bin = 1'b1;
      tick();
      chk(r_rdata, 36'h4_4444_4444, "R8 busy input keeps reads");
      r_idle();
      ms_master = 1'b1;

      // R9: sleep freezes the left port
      l_rd(0, 4'h0);
      tick();
      chk(l_rdata, pat(0), "R9 read before sleep");
      l_wr(1, ~pat(1), 4'h0); l_sleep = 1'b1; r_rd(1, 4'h0);
      #1;
      chk({34'b0, l_busy, r_busy}, 36'h0, "R9 sleeper not arbitrated");
      tick();
      chk(l_rdata, pat(0), "R9 read data held while sleeping");
      l_rd(2, 4'h0); l_sleep = 1'b1;
      tick();
      chk(l_rdata, pat(0), "R9 address change ignored while sleeping");
      l_idle(); r_idle();
      peek(1, pat(1), "R9 write ignored while sleeping");

      summary();
      $finish;
   end

endmodule